// File: doc/BRIEF.md
# SPI Card Host Controller

This block is a memory-mapped SPI master meant to sit between a processor bus and a flash memory card running in SPI mode. Software reaches it through a small word-wide slave port: eight 16-bit registers selected by a 3-bit word address, with separate read and write strobes and a read data path that follows the address in the same cycle. All card protocol work (commands, initialisation, block framing) stays in software. The hardware moves bytes, keeps running CRC-7 and CRC-16 values over a chosen direction, and reports status.

Transmit and receive each have one byte of holding storage around a single shift engine. A byte written to the transmit holding register starts shifting as soon as the engine is idle. The serial clock is the system clock divided by a run-time divisor, which may be odd. Every received byte lands in the receive holding register. Overrun on either side is flagged. A software-started millisecond timer, card-detect and write-protect status, and a level interrupt built from status bits and their enables complete the block.

Top module: `sdspi_host`

## Requirements
- R1: After reset: status reads 0x0060 when wp=0 and cd_n=1; control reads 0; slaveselect reads 1; cs_n is 1, sclk is 0, irq is 0. The register word addresses are 0 receive data, 1 transmit data, 2 status, 3 control, 4 CRC-7, 5 slaveselect, 6 clock control, 7 CRC-16.
- R2: Status bits are 0 timer done, 1 write protect, 3 receive overrun, 4 transmit overrun, 5 shifter empty, 6 transmit ready, 7 receive ready, 8 error (OR of bits 3 and 4), 11 card present. All other bits read 0.
- R3: A transmit-data write when transmit ready is 1 stores the low byte and clears transmit ready. The byte moves into the shifter in the first cycle the shifter is idle, and transmit ready returns to 1 in that cycle. The byte goes out on mosi MSB first, in SPI mode 0: sclk idles low, data changes after falling edges and is sampled on rising edges. Each bit lasts N system clocks, with sclk low for ceil(N/2) of them and high for floor(N/2). cs_n is low for exactly 8N cycles per byte.
- R4: A transmit-data write while transmit ready is 0 sets transmit overrun and is discarded; the held byte and the bytes shifted are unchanged.
- R5: After 8 bits, the received byte always lands in receive data and sets receive ready. A read of receive data clears receive ready. Writes to receive data have no effect.
- R6: A byte that arrives while receive ready is 1 sets receive overrun and replaces the old byte. This does not apply when receive data is read in that same cycle; then only receive ready stays set.
- R7: Any write to status clears both overrun bits and the error bit. A read of status changes no bit other than timer done.
- R8: Writing control with bit 0 set starts a timer. Timer done becomes 1 exactly MS_TICKS cycles after that write and clears on the next status read.
- R9: irq is 1 whenever a status bit and its enable are both 1. The enables are control bits 3 (receive overrun), 4 (transmit overrun), 6 (transmit ready), 7 (receive ready), 8 (error) and 11 (card present).
- R10: cs_n is low when slaveselect bit 0 is 1 and either a byte is shifting or control bit 10 (forced select) is 1. It is high otherwise.
- R11: Clock control always reads {SYS_MHZ[7:0], DIV_INIT[7:0]}. Writing it sets N from the low byte for later bytes, with values below 2 taken as 2.
- R12: Control bit 1 is a strobe that zeroes both CRCs. Control bit 2 picks the CRC input: 1 for mosi bits, 0 for miso bits. Each sampled bit advances CRC-7 (x^7+x^3+1) and CRC-16 (x^16+x^12+x^5+1), both MSB-first with zero start. Control bits 0 and 1 read back as 0.
- R13: Status bit 1 follows the wp pin and status bit 11 is the inverse of the cd_n pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| irq | output | 1 | Level interrupt request |
| sclk | output | 1 | Serial clock to the card |
| cs_n | output | 1 | Active-low card select |
| mosi | output | 1 | Serial data to the card |
| miso | input | 1 | Serial data from the card |
| wp | input | 1 | Write-protect switch |
| cd_n | input | 1 | Card detect, low when a card is present |

## Verification
Two pairs of functions can land in the same cycle here. The first pair is the completion of a received byte and a software read of receive data. The bench counts cycles from the falling edge of cs_n and places the read strobe on the last cycle of the byte. It expects the old byte to be returned, receive ready to stay set and no overrun to be flagged. The second pair is a byte entering the shifter and a new transmit-data write; the bench holds one byte and writes a third, and expects the overrun flag with that third byte absent from mosi.

// File: rtl/sdspi_pkg.sv
`timescale 1ns/1ps
package sdspi_pkg;
  // register word addresses
  localparam logic [2:0] ADR_RXD  = 3'd0;
  localparam logic [2:0] ADR_TXD  = 3'd1;
  localparam logic [2:0] ADR_STAT = 3'd2;
  localparam logic [2:0] ADR_CTRL = 3'd3;
  localparam logic [2:0] ADR_CRC7 = 3'd4;
  localparam logic [2:0] ADR_SSEL = 3'd5;
  localparam logic [2:0] ADR_CLK  = 3'd6;
  localparam logic [2:0] ADR_CRC16= 3'd7;

  // status bit positions
  localparam int ST_MS   = 0;
  localparam int ST_WP   = 1;
  localparam int ST_ROE  = 3;
  localparam int ST_TOE  = 4;
  localparam int ST_TMT  = 5;
  localparam int ST_TRDY = 6;
  localparam int ST_RRDY = 7;
  localparam int ST_ERR  = 8;
  localparam int ST_CD   = 11;

  // control bit positions
  localparam int CT_GO   = 0;
  localparam int CT_CLR  = 1;
  localparam int CT_DIR  = 2;
  localparam int CT_SSO  = 10;
  localparam int CT_IRRDY = 7;

  // stored control bits and interrupt-capable status bits
  localparam logic [15:0] CTRL_KEEP = 16'h0DDC;
  localparam logic [15:0] IRQ_MASK  = 16'h09D8;

  function automatic logic [6:0] crc7_step(logic [6:0] c, logic b);
    logic fb;
    fb = c[6] ^ b;
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [15:0] crc16_step(logic [15:0] c, logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction
endpackage

// File: rtl/sdspi_shifter.sv
`timescale 1ns/1ps
module sdspi_shifter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             load,
  input  logic [7:0]       load_byte,
  input  logic             miso,
  output logic             busy,
  output logic             sclk,
  output logic             mosi,
  output logic             sample,
  output logic             sample_tx,
  output logic             sample_rx,
  output logic             done,
  output logic [7:0]       rx_byte
);
  logic             busy_q, busy_n;
  logic             sclk_q, sclk_n;
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic [DIV_W-1:0] per_q, per_n;
  logic [2:0]       idx_q, idx_n;
  logic [7:0]       tx_q, tx_n;
  logic [7:0]       rx_q, rx_n;
  logic [DIV_W-1:0] lo_len;
  logic             rise, last;

  // low phase takes the larger half when the divisor is odd
  assign lo_len = per_q - (per_q >> 1);
  assign rise   = busy_q && (cnt_q == lo_len - DIV_W'(1));
  assign last   = busy_q && (cnt_q == per_q - DIV_W'(1));

  always_comb begin
    busy_n = busy_q;
    sclk_n = sclk_q;
    cnt_n  = cnt_q;
    per_n  = per_q;
    idx_n  = idx_q;
    tx_n   = tx_q;
    rx_n   = rx_q;
    if (!busy_q) begin
      if (load) begin
        busy_n = 1'b1;
        tx_n   = load_byte;
        cnt_n  = '0;
        idx_n  = '0;
        per_n  = div;
        sclk_n = 1'b0;
      end
    end else if (last) begin
      cnt_n  = '0;
      sclk_n = 1'b0;
      if (idx_q == 3'd7) begin
        busy_n = 1'b0;
      end else begin
        idx_n = idx_q + 3'd1;
        tx_n  = {tx_q[6:0], 1'b0};
      end
    end else begin
      cnt_n = cnt_q + DIV_W'(1);
      if (rise) begin
        sclk_n = 1'b1;
        rx_n   = {rx_q[6:0], miso};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      per_q  <= DIV_W'(2);
      idx_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_n;
      sclk_q <= sclk_n;
      cnt_q  <= cnt_n;
      per_q  <= per_n;
      idx_q  <= idx_n;
      tx_q   <= tx_n;
      rx_q   <= rx_n;
    end
  end

  assign busy      = busy_q;
  assign sclk      = sclk_q;
  assign mosi      = tx_q[7];
  assign sample    = rise;
  assign sample_tx = tx_q[7];
  assign sample_rx = miso;
  assign done      = last && (idx_q == 3'd7);
  assign rx_byte   = rx_q;
endmodule

// File: rtl/sdspi_mstimer.sv
`timescale 1ns/1ps
module sdspi_mstimer #(
  parameter int TICKS = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire
);
  localparam int CW = $clog2(TICKS + 1);
  logic [CW-1:0] cnt_q, cnt_n;
  logic          run_q, run_n;

  assign expire = run_q && (cnt_q == '0);

  always_comb begin
    cnt_n = cnt_q;
    run_n = run_q;
    if (start) begin
      cnt_n = CW'(TICKS - 1);
      run_n = 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_n = 1'b0;
      else             cnt_n = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      run_q <= run_n;
    end
  end
endmodule

// File: rtl/sdspi_crc.sv
`timescale 1ns/1ps
module sdspi_crc
  import sdspi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        step,
  input  logic        bit_in,
  output logic [6:0]  crc7,
  output logic [15:0] crc16
);
  logic [6:0]  c7_q, c7_n;
  logic [15:0] c16_q, c16_n;

  always_comb begin
    c7_n  = c7_q;
    c16_n = c16_q;
    if (clear) begin
      c7_n  = '0;
      c16_n = '0;
    end else if (step) begin
      c7_n  = crc7_step(c7_q, bit_in);
      c16_n = crc16_step(c16_q, bit_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c7_q  <= '0;
      c16_q <= '0;
    end else begin
      c7_q  <= c7_n;
      c16_q <= c16_n;
    end
  end

  assign crc7  = c7_q;
  assign crc16 = c16_q;
endmodule

// File: rtl/sdspi_host.sv
`timescale 1ns/1ps
module sdspi_host
  import sdspi_pkg::*;
#(
  parameter int SYS_MHZ  = 125,
  parameter int DIV_INIT = 5,
  parameter int MS_TICKS = 125000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi,
  input  logic        miso,
  input  logic        wp,
  input  logic        cd_n
);
  localparam int DIV_W = 8;
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);
  localparam logic [DIV_W-1:0] DIV_RST = (DIV_INIT < 2) ? DIV_MIN : DIV_W'(DIV_INIT);
  localparam logic [7:0]       MHZ_TAG = 8'(SYS_MHZ);

  // bus decode
  logic wr_tx, wr_rx, wr_stat, wr_ctrl, wr_ss, wr_clk, rd_rx, rd_stat;
  assign wr_tx   = bus_wr && (bus_addr == ADR_TXD);
  assign wr_rx   = bus_wr && (bus_addr == ADR_RXD);
  assign wr_stat = bus_wr && (bus_addr == ADR_STAT);
  assign wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);
  assign wr_ss   = bus_wr && (bus_addr == ADR_SSEL);
  assign wr_clk  = bus_wr && (bus_addr == ADR_CLK);
  assign rd_rx   = bus_rd && (bus_addr == ADR_RXD);
  assign rd_stat = bus_rd && (bus_addr == ADR_STAT);

  // state
  logic [7:0]       rx_q, rx_n;
  logic [7:0]       txh_q, txh_n;
  logic             tx_full_q, tx_full_n;
  logic             rrdy_q, rrdy_n;
  logic             roe_q, roe_n;
  logic             toe_q, toe_n;
  logic             ms_q, ms_n;
  logic [15:0]      ctrl_q, ctrl_n;
  logic             ss_q, ss_n;
  logic [DIV_W-1:0] div_q, div_n;

  // engine links
  logic       busy, load, sample, sample_tx, sample_rx, done, expire;
  logic [7:0] rx_byte;
  logic [6:0] crc7;
  logic [15:0] crc16;
  logic       go, crc_clr;
  logic [15:0] stat;

  assign load    = tx_full_q && !busy;
  assign go      = wr_ctrl && bus_wdata[CT_GO];
  assign crc_clr = wr_ctrl && bus_wdata[CT_CLR];

  sdspi_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .div       (div_q),
    .load      (load),
    .load_byte (txh_q),
    .miso      (miso),
    .busy      (busy),
    .sclk      (sclk),
    .mosi      (mosi),
    .sample    (sample),
    .sample_tx (sample_tx),
    .sample_rx (sample_rx),
    .done      (done),
    .rx_byte   (rx_byte)
  );

  sdspi_mstimer #(.TICKS(MS_TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (go),
    .expire (expire)
  );

  sdspi_crc u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (crc_clr),
    .step   (sample),
    .bit_in (ctrl_q[CT_DIR] ? sample_tx : sample_rx),
    .crc7   (crc7),
    .crc16  (crc16)
  );

  // next state
  always_comb begin
    rx_n      = rx_q;
    txh_n     = txh_q;
    tx_full_n = tx_full_q;
    rrdy_n    = rrdy_q;
    roe_n     = roe_q;
    toe_n     = toe_q;
    ms_n      = ms_q;
    ctrl_n    = ctrl_q;
    ss_n      = ss_q;
    div_n     = div_q;

    if (wr_stat) begin
      roe_n = 1'b0;
      toe_n = 1'b0;
    end

    if (load) tx_full_n = 1'b0;
    if (wr_tx) begin
      if (tx_full_q) begin
        toe_n = 1'b1;
      end else begin
        txh_n     = bus_wdata[7:0];
        tx_full_n = 1'b1;
      end
    end

    if (done) begin
      rx_n   = rx_byte;
      rrdy_n = 1'b1;
      if (rrdy_q && !rd_rx) roe_n = 1'b1;
    end else if (rd_rx) begin
      rrdy_n = 1'b0;
    end

    if (expire)       ms_n = 1'b1;
    else if (rd_stat) ms_n = 1'b0;

    if (wr_ctrl) ctrl_n = bus_wdata & CTRL_KEEP;
    if (wr_ss)   ss_n   = bus_wdata[0];
    if (wr_clk)  div_n  = (bus_wdata[7:0] < DIV_MIN) ? DIV_MIN : bus_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q      <= '0;
      txh_q     <= '0;
      tx_full_q <= 1'b0;
      rrdy_q    <= 1'b0;
      roe_q     <= 1'b0;
      toe_q     <= 1'b0;
      ms_q      <= 1'b0;
      ctrl_q    <= '0;
      ss_q      <= 1'b1;
      div_q     <= DIV_RST;
    end else begin
      rx_q      <= rx_n;
      txh_q     <= txh_n;
      tx_full_q <= tx_full_n;
      rrdy_q    <= rrdy_n;
      roe_q     <= roe_n;
      toe_q     <= toe_n;
      ms_q      <= ms_n;
      ctrl_q    <= ctrl_n;
      ss_q      <= ss_n;
      div_q     <= div_n;
    end
  end

  // status word
  always_comb begin
    stat          = '0;
    stat[ST_MS]   = ms_q;
    stat[ST_WP]   = wp;
    stat[ST_ROE]  = roe_q;
    stat[ST_TOE]  = toe_q;
    stat[ST_TMT]  = !busy;
    stat[ST_TRDY] = !tx_full_q;
    stat[ST_RRDY] = rrdy_q;
    stat[ST_ERR]  = roe_q | toe_q;
    stat[ST_CD]   = !cd_n;
  end

  assign irq  = |(stat & ctrl_q & IRQ_MASK);
  assign cs_n = !(ss_q && (busy || ctrl_q[CT_SSO]));

  always_comb begin
    case (bus_addr)
      ADR_RXD:  bus_rdata = {8'h00, rx_q};
      ADR_TXD:  bus_rdata = {8'h00, txh_q};
      ADR_STAT: bus_rdata = stat;
      ADR_CTRL: bus_rdata = ctrl_q;
      ADR_CRC7: bus_rdata = {9'h000, crc7};
      ADR_SSEL: bus_rdata = {15'h0000, ss_q};
      ADR_CLK:  bus_rdata = {MHZ_TAG, DIV_RST};
      default:  bus_rdata = crc16;
    endcase
  end

  // writes to receive data are decoded but have no target
  logic unused_ok;
  assign unused_ok = wr_rx;
endmodule

// File: rtl/sdspi_host_chk.sv
`timescale 1ns/1ps
module sdspi_host_chk
  import sdspi_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  bus_addr,
  input logic        bus_wr,
  input logic        tx_full_q,
  input logic        toe_q,
  input logic        rrdy_q,
  input logic        busy,
  input logic        sclk,
  input logic        mosi,
  input logic        cs_n,
  input logic        ss_q,
  input logic [15:0] ctrl_q,
  input logic        irq
);
  // R3: an accepted transmit write leaves a byte held
  p_hold_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_TXD && !tx_full_q) |=> tx_full_q);

  // R4: a write while holding flags overrun
  p_overrun_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_TXD && tx_full_q) |=> toe_q);

  // R3: serial clock idles low
  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  // R3: data holds steady while the clock is high
  p_mosi_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R5: a new received byte coincides with the end of shifting
  p_rx_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rrdy_q) |-> $fell(busy));

  // R10: select follows shifting and the mask bit
  p_cs_during_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ss_q) |-> !cs_n);
  p_cs_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_q |-> cs_n);

  // R9: receive-ready interrupt when enabled
  p_irq_rrdy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rrdy_q && ctrl_q[CT_IRRDY]) |-> irq);
endmodule

bind sdspi_host sdspi_host_chk u_chk (.*);

// File: tb/sdspi_host_bench.sv
`timescale 1ns/1ps
module sdspi_host_bench;
  localparam int MS_T = 300;
  localparam int DIV0 = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_rd, bus_wr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        irq, sclk, cs_n, mosi, miso, wp, cd_n;

  always #4 clk = ~clk;

  sdspi_host #(.SYS_MHZ(125), .DIV_INIT(DIV0), .MS_TICKS(MS_T)) u_sdspi_host (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk),
    .cs_n(cs_n), .mosi(mosi), .miso(miso), .wp(wp), .cd_n(cd_n)
  );

  // card model: one bit per falling sclk edge
  logic [7:0]  card_byte = 8'h00;
  logic [2:0]  card_bit = 3'd0;
  logic [31:0] mosi_log = '0;
  assign miso = card_byte[3'd7 - card_bit];
  always @(negedge sclk) card_bit <= card_bit + 3'd1;
  always @(posedge sclk) mosi_log <= {mosi_log[30:0], mosi};

  int vectors = 0;
  int misses = 0;
  int cur_div = DIV0;
  int last_low;
  logic        dir_m = 1'b0;
  logic [6:0]  m7 = '0;
  logic [15:0] m16 = '0;
  logic [15:0] rv;
  logic [15:0] ctrl_sh = '0;
  bit          finished = 0;

  function automatic logic [6:0] f7(logic [6:0] c, logic b);
    logic t;
    t = c[6] ^ b;
    return {c[5:0], 1'b0} ^ (t ? 7'h09 : 7'h00);
  endfunction
  function automatic logic [15:0] f16(logic [15:0] c, logic b);
    logic t;
    t = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (t ? 16'h1021 : 16'h0000);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic model(input logic [7:0] tx, input logic [7:0] cb);
    for (int i = 7; i >= 0; i--) begin
      m7  = f7(m7, dir_m ? tx[i] : cb[i]);
      m16 = f16(m16, dir_m ? tx[i] : cb[i]);
    end
  endtask

  task automatic crc_clear(input logic dir);
    dir_m = dir; m7 = '0; m16 = '0;
    ctrl_sh = dir ? 16'h0004 : 16'h0000;
    wr(3'd3, ctrl_sh | 16'h0002);
  endtask

  // one byte with select enabled; measures cycles with cs_n low
  task automatic xfer(input logic [7:0] tx, input logic [7:0] cb);
    card_byte = cb;
    wr(3'd1, {8'h00, tx});
    last_low = 0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (!cs_n) last_low++;
      else if (last_low > 0) break;
    end
    model(tx, cb);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
    wp = 1'b0; cd_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd2, rv); check("R1 status", rv, 16'h0060);
    rd(3'd3, rv); check("R1 control", rv, 16'h0000);
    rd(3'd5, rv); check("R1 slaveselect", rv, 16'h0001);
    check("R1 pins cs_n/sclk/irq", {cs_n, sclk, irq}, 3'b100);
    rd(3'd6, rv); check("R11 clock control", rv, {8'd125, 8'd5});

    // R13 / R2 pin mirrors
    wp = 1'b1; cd_n = 1'b0;
    rd(3'd2, rv); check("R13 wp and card present", rv, 16'h0862);
    wp = 1'b0; cd_n = 1'b1;
    rd(3'd2, rv); check("R13 pins released", rv, 16'h0060);

    // R3 / R5 single byte
    xfer(8'hA5, 8'h3C);
    check("R3 mosi byte", mosi_log[7:0], 8'hA5);
    check("R3 cs_n low cycles", last_low, 8 * DIV0);
    rd(3'd2, rv); check("R5 rrdy set", rv, 16'h00E0);
    rd(3'd0, rv); check("R5 rx byte", rv, 16'h003C);
    rd(3'd2, rv); check("R5 rrdy cleared by read", rv, 16'h0060);
    wr(3'd0, 16'h00FF);
    rd(3'd0, rv); check("R5 write to rxdata ignored", rv, 16'h003C);
    rd(3'd2, rv); check("R5 status unchanged by rx write", rv, 16'h0060);

    // R3 holding register queue and R6 overrun
    card_byte = 8'h81;
    wr(3'd1, 16'h0011);
    repeat (2) @(negedge clk);
    rd(3'd2, rv); check("R3 trdy back once loaded", rv, 16'h0040);
    wr(3'd1, 16'h0022);
    rd(3'd2, rv); check("R3 trdy low while held", rv, 16'h0000);
    repeat (16 * DIV0 + 10) @(negedge clk);
    model(8'h11, 8'h81); model(8'h22, 8'h81);
    check("R3 two queued bytes", mosi_log[15:0], 16'h1122);
    rd(3'd2, rv); check("R6 overrun flagged", rv, 16'h01E8);
    rd(3'd2, rv); check("R7 status read keeps flags", rv, 16'h01E8);
    rd(3'd0, rv); check("R6 newest byte kept", rv, 16'h0081);
    wr(3'd2, 16'h0000);
    rd(3'd2, rv); check("R7 status write clears errors", rv, 16'h0060);

    // R4 transmit overrun
    card_byte = 8'h00;
    wr(3'd1, 16'h005A);
    wr(3'd1, 16'h00C3);
    wr(3'd1, 16'h00E7);
    rd(3'd2, rv); check("R4 toe while held", rv, 16'h0110);
    repeat (16 * DIV0 + 10) @(negedge clk);
    model(8'h5A, 8'h00); model(8'hC3, 8'h00);
    check("R4 discarded byte not sent", mosi_log[15:0], 16'h5AC3);
    rd(3'd2, rv); check("R4 flags after both bytes", rv, 16'h01F8);
    rd(3'd0, rv);
    wr(3'd2, 16'h0000);
    rd(3'd2, rv); check("R7 clear after toe", rv, 16'h0060);

    // R6 read in the same cycle as arrival
    xfer(8'h01, 8'h96);
    card_byte = 8'h69;
    wr(3'd1, 16'h0002);
    @(negedge clk);
    while (cs_n) @(negedge clk);
    repeat (8 * DIV0 - 1) @(negedge clk);
    bus_addr = 3'd0; bus_rd = 1'b1;
    #1 rv = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
    model(8'h02, 8'h69);
    check("R6 coincident read returns old byte", rv, 16'h0096);
    rd(3'd2, rv); check("R6 no overrun on coincident read", rv, 16'h00E0);
    rd(3'd0, rv); check("R6 new byte present", rv, 16'h0069);

    // R11 divisor changes
    wr(3'd6, 16'h0003); cur_div = 3;
    rd(3'd6, rv); check("R11 read returns default", rv, {8'd125, 8'd5});
    xfer(8'h3E, 8'hD2);
    check("R11 odd divisor 3", last_low, 24);
    rd(3'd0, rv); check("R5 rx at divisor 3", rv, 16'h00D2);
    wr(3'd6, 16'h0000); cur_div = 2;
    xfer(8'hC7, 8'h4B);
    check("R11 divisor clamped to 2", last_low, 16);
    check("R3 mosi at divisor 2", mosi_log[7:0], 8'hC7);
    rd(3'd0, rv); check("R5 rx at divisor 2", rv, 16'h004B);

    // R3 / R5 random bytes at random divisors
    for (int n = 0; n < 16; n++) begin
      logic [7:0] t, c;
      cur_div = 2 + int'($urandom % 6);
      t = 8'($urandom); c = 8'($urandom);
      wr(3'd6, 16'(cur_div));
      xfer(t, c);
      check("R3 random mosi", mosi_log[7:0], t);
      check("R3 random byte time", last_low, 8 * cur_div);
      rd(3'd0, rv); check("R5 random rx", rv, {8'h00, c});
    end
    wr(3'd6, 16'h0004); cur_div = 4;

    // R12 CRC over transmitted command bytes
    crc_clear(1'b1);
    rd(3'd3, rv); check("R12 strobes read zero", rv, 16'h0004);
    xfer(8'h40, 8'hFF); xfer(8'h00, 8'hFF); xfer(8'h00, 8'hFF);
    xfer(8'h00, 8'hFF); xfer(8'h00, 8'hFF);
    rd(3'd4, rv); check("R12 crc7 of idle command", rv, 16'h004A);
    check("R12 crc7 model tx", rv, {9'h0, m7});
    rd(3'd7, rv); check("R12 crc16 model tx", rv, m16);
    crc_clear(1'b0);
    for (int n = 0; n < 4; n++) xfer(8'($urandom), 8'($urandom));
    rd(3'd7, rv); check("R12 crc16 model rx", rv, m16);
    rd(3'd4, rv); check("R12 crc7 model rx", rv, {9'h0, m7});
    rd(3'd0, rv);
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h0000);

    // R8 timer
    wr(3'd3, 16'h0001);
    repeat (MS_T - 3) @(negedge clk);
    rd(3'd2, rv); check("R8 timer not yet done", rv, 16'h0060);
    rd(3'd2, rv); check("R8 timer done on time", rv, 16'h0061);
    rd(3'd2, rv); check("R8 timer cleared by read", rv, 16'h0060);

    // R9 interrupts
    wr(3'd3, 16'h0080);
    check("R9 no irq while empty", irq, 1'b0);
    xfer(8'h10, 8'h20);
    check("R9 irq on rrdy", irq, 1'b1);
    rd(3'd0, rv);
    @(negedge clk); check("R9 irq drops after read", irq, 1'b0);
    wr(3'd3, 16'h0800);
    cd_n = 1'b0; @(negedge clk); check("R9 irq on card present", irq, 1'b1);
    cd_n = 1'b1; @(negedge clk); check("R9 irq follows card detect", irq, 1'b0);
    wr(3'd3, 16'h0100);
    xfer(8'h01, 8'h02); xfer(8'h03, 8'h04);
    check("R9 irq on error", irq, 1'b1);
    wr(3'd2, 16'h0000);
    @(negedge clk); check("R9 irq clears with error", irq, 1'b0);
    rd(3'd0, rv);
    wr(3'd3, 16'h0040);
    @(negedge clk); check("R9 irq on trdy", irq, 1'b1);
    wr(3'd3, 16'h0000);

    // R10 chip select control
    wr(3'd3, 16'h0400);
    check("R10 forced select while idle", cs_n, 1'b0);
    wr(3'd3, 16'h0000);
    check("R10 select released", cs_n, 1'b1);
    wr(3'd5, 16'h0000);
    card_byte = 8'h55;
    wr(3'd1, 16'h00AA);
    last_low = 0;
    for (int k = 0; k < 8 * cur_div + 6; k++) begin
      @(negedge clk);
      if (!cs_n) last_low++;
    end
    check("R10 masked select stays high", last_low, 0);
    check("R3 byte still shifted when masked", mosi_log[7:0], 8'hAA);
    wr(3'd5, 16'h0001);
    rd(3'd5, rv); check("R10 slaveselect restored", rv, 16'h0001);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule